// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block sits between a CPU with a 16-bit byte-wide bus and the devices behind it. Each CPU access is decoded and sent to one of four targets: a 256-byte boot ROM read port, a cartridge read/write port, a small internal work RAM, or a single control location. After reset, the boot ROM is mapped over the bottom of the cartridge ROM window. The first fetch from address 0x0000 therefore returns boot code. Addresses from 0x0100 upward in the ROM window always reach the cartridge.

Boot code leaves the overlay by writing 0x01 to the control location 0xFF50. This clears a sticky latch, and from then on the low 256 bytes come from the cartridge. No later write can bring the boot ROM back; only a reset does. Any read that no device backs returns the open-bus value 0xFF. Cartridge reads also return 0xFF while the cartridge is absent. Read data comes back one clock after the request, marked by a one-cycle valid pulse.

Top module: `boot_overlay_router`

## Requirements
- R1: From reset until the overlay is switched off, a read of 0x0000–0x00FF asserts `boot_rd` with `boot_addr` equal to the address low byte and without `cart_rd`; the returned byte is `boot_data`.
- R2: A read of 0x0100–0x7FFF always asserts `cart_rd` with `cart_addr` equal to the CPU address and returns `cart_rdata`, whatever the overlay state.
- R3: A write of exactly 0x01 to 0xFF50 switches the overlay off; from the next access on, reads of 0x0000–0x00FF go to the cartridge port.
- R4: A write of any other value to 0xFF50 leaves the overlay state unchanged.
- R5: Once switched off, the overlay stays off under every later write, including writes to 0xFF50; only a reset turns it on again.
- R6: A read of 0xFF50 returns 0xFE while the overlay is on and 0xFF after it is off.
- R7: Reads of unbacked addresses (0x8000–0xBFFF, 0xE000–0xFFFF except 0xFF50) return 0xFF and strobe no device.
- R8: While `cart_present` is low, every read routed to the cartridge returns 0xFF.
- R9: Addresses 0xC000–0xDFFF read and write the internal work RAM; the word index is the address modulo 2^WRAM_AW, so the array repeats across the window.
- R10: A write to 0x0000–0x7FFF asserts `cart_wr` in the same cycle, with `cart_addr` and `cart_wdata` equal to the CPU address and data, whether or not the overlay is on; it produces no read response.
- R11: A read (`cpu_rd` high, `cpu_wr` low) gives `cpu_rvalid` high for exactly the following cycle with the data in `cpu_rdata`; idle cycles and writes give no `cpu_rvalid`. When both strobes are high, the access is a write.
- R12: After reset, `cpu_rvalid` is low and `cpu_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, registered |
| cpu_rvalid | output | 1 | Read data valid pulse |
| boot_addr | output | 8 | Boot ROM byte index |
| boot_rd | output | 1 | Boot ROM read strobe |
| boot_data | input | 8 | Boot ROM byte, same cycle |
| cart_addr | output | 16 | Cartridge address |
| cart_rd | output | 1 | Cartridge read strobe |
| cart_wr | output | 1 | Cartridge write strobe |
| cart_wdata | output | 8 | Cartridge write data |
| cart_rdata | input | 8 | Cartridge read byte, same cycle |
| cart_present | input | 1 | Cartridge inserted |

## Verification
The one piece of state that matters is the overlay latch. If it holds the wrong value, it shows within one access of the low 256 bytes: the read strobe goes to the wrong port in the same cycle, and the wrong byte appears one clock later. It also shows on any read of 0xFF50, where the low bit of the returned byte gives the latch state. A stale work RAM word or a wrong target held in the return stage shows on the very next read pulse. The bench therefore checks the strobes during every cycle and checks the data of every read pulse.

// File: rtl/bor_pkg.sv
package bor_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_BOOT = 3'd1,
    TGT_CART = 3'd2,
    TGT_WRAM = 3'd3,
    TGT_CTRL = 3'd4
  } tgt_e;
endpackage

// File: rtl/bor_decode.sv
module bor_decode
  import bor_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BOOT_AW = 8,
  parameter logic [ADDR_W-1:0] ROM_LAST = 'h7FFF,
  parameter logic [ADDR_W-1:0] WRAM_FIRST = 'hC000,
  parameter logic [ADDR_W-1:0] WRAM_LAST = 'hDFFF,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hFF50
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_wr,
  input  logic              overlay_on,
  output tgt_e              tgt
);
  localparam int HI_W = ADDR_W - BOOT_AW;

  logic in_rom;
  logic in_boot;
  logic in_wram;

  always_comb begin
    in_rom  = (addr <= ROM_LAST);
    in_boot = (addr[ADDR_W-1:BOOT_AW] == {HI_W{1'b0}});
    in_wram = (addr >= WRAM_FIRST) && (addr <= WRAM_LAST);
    tgt     = TGT_NONE;
    if (in_rom) begin
      // the boot overlay only captures reads; writes reach the cartridge
      if (in_boot && overlay_on && !is_wr) tgt = TGT_BOOT;
      else                                 tgt = TGT_CART;
    end else if (in_wram) begin
      tgt = TGT_WRAM;
    end else if (addr == CTRL_ADDR) begin
      tgt = TGT_CTRL;
    end
  end
endmodule

// File: rtl/bor_latch.sv
module bor_latch #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] OFF_KEY = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              overlay_on
);
  logic off_q;
  logic off_d;
  logic off_en;

  always_comb begin
    off_en = ctrl_wr && (wdata == OFF_KEY) && !off_q;
    off_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= 1'b0;
    else if (off_en) off_q <= off_d;
  end

  assign overlay_on = !off_q;
endmodule

// File: rtl/bor_wram.sv
module bor_wram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/bor_resp.sv
module bor_resp
  import bor_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] OPEN_BUS = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_acc,
  input  tgt_e              tgt,
  input  logic [DATA_W-1:0] boot_byte,
  input  logic [DATA_W-1:0] cart_byte,
  input  logic [DATA_W-1:0] ctrl_byte,
  input  logic [DATA_W-1:0] wram_byte,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              valid_q;
  logic              from_wram_q;
  logic              from_wram_d;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    from_wram_d = (tgt == TGT_WRAM);
    case (tgt)
      TGT_BOOT: data_d = boot_byte;
      TGT_CART: data_d = cart_byte;
      TGT_CTRL: data_d = ctrl_byte;
      default:  data_d = OPEN_BUS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= rd_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q      <= OPEN_BUS;
      from_wram_q <= 1'b0;
    end else if (rd_acc) begin
      data_q      <= data_d;
      from_wram_q <= from_wram_d;
    end
  end

  assign rvalid = valid_q;
  assign rdata  = from_wram_q ? wram_byte : data_q;
endmodule

// File: rtl/boot_overlay_router.sv
module boot_overlay_router
  import bor_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BOOT_AW = 8,
  parameter int WRAM_AW = 10,
  parameter logic [ADDR_W-1:0] ROM_LAST = 'h7FFF,
  parameter logic [ADDR_W-1:0] WRAM_FIRST = 'hC000,
  parameter logic [ADDR_W-1:0] WRAM_LAST = 'hDFFF,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hFF50,
  parameter logic [DATA_W-1:0] OFF_KEY = 'h01,
  parameter logic [DATA_W-1:0] OPEN_BUS = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic [BOOT_AW-1:0] boot_addr,
  output logic              boot_rd,
  input  logic [DATA_W-1:0] boot_data,
  output logic [ADDR_W-1:0] cart_addr,
  output logic              cart_rd,
  output logic              cart_wr,
  output logic [DATA_W-1:0] cart_wdata,
  input  logic [DATA_W-1:0] cart_rdata,
  input  logic              cart_present
);
  localparam int SYNC_N = 2;

  // asynchronous assertion, synchronous release
  logic [SYNC_N-1:0] rst_sync;
  logic              rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync[SYNC_N-1];

  tgt_e              tgt;
  logic              overlay_on;
  logic              rd_acc;
  logic              ctrl_wr;
  logic              wram_we;
  logic              wram_re;
  logic [DATA_W-1:0] cart_byte;
  logic [DATA_W-1:0] ctrl_byte;
  logic [DATA_W-1:0] wram_byte;

  bor_decode #(
    .ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .ROM_LAST(ROM_LAST),
    .WRAM_FIRST(WRAM_FIRST), .WRAM_LAST(WRAM_LAST), .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .addr(cpu_addr), .is_wr(cpu_wr), .overlay_on(overlay_on), .tgt(tgt)
  );

  always_comb begin
    rd_acc  = cpu_rd && !cpu_wr;
    ctrl_wr = cpu_wr && (tgt == TGT_CTRL);
    wram_we = cpu_wr && (tgt == TGT_WRAM);
    wram_re = rd_acc && (tgt == TGT_WRAM);
    boot_rd = rd_acc && (tgt == TGT_BOOT);
    cart_rd = rd_acc && (tgt == TGT_CART);
    cart_wr = cpu_wr && (tgt == TGT_CART);
    cart_byte = cart_present ? cart_rdata : OPEN_BUS;
    ctrl_byte = {{(DATA_W-1){1'b1}}, !overlay_on};
  end

  assign boot_addr  = cpu_addr[BOOT_AW-1:0];
  assign cart_addr  = cpu_addr;
  assign cart_wdata = cpu_wdata;

  bor_latch #(.DATA_W(DATA_W), .OFF_KEY(OFF_KEY)) u_latch (
    .clk(clk), .rst_n(rst_i_n), .ctrl_wr(ctrl_wr), .wdata(cpu_wdata),
    .overlay_on(overlay_on)
  );

  bor_wram #(.AW(WRAM_AW), .DW(DATA_W)) u_wram (
    .clk(clk), .we(wram_we), .re(wram_re), .addr(cpu_addr[WRAM_AW-1:0]),
    .wdata(cpu_wdata), .rdata(wram_byte)
  );

  bor_resp #(.DATA_W(DATA_W), .OPEN_BUS(OPEN_BUS)) u_resp (
    .clk(clk), .rst_n(rst_i_n), .rd_acc(rd_acc), .tgt(tgt),
    .boot_byte(boot_data), .cart_byte(cart_byte), .ctrl_byte(ctrl_byte),
    .wram_byte(wram_byte), .rdata(cpu_rdata), .rvalid(cpu_rvalid)
  );
endmodule

// File: rtl/bor_chk.sv
module bor_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_rdata,
  input logic        cpu_rvalid,
  input logic        boot_rd,
  input logic        cart_rd,
  input logic        cart_wr,
  input logic        cart_present,
  input logic        overlay_on
);
  logic rd_acc;
  assign rd_acc = cpu_rd && !cpu_wr;

  assert_boot_fetch_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_acc && overlay_on && cpu_addr[15:8] == 8'h00) |-> (boot_rd && !cart_rd));

  assert_boot_window_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    boot_rd |-> (cpu_addr[15:8] == 8'h00));

  assert_upper_rom_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_acc && cpu_addr >= 16'h0100 && cpu_addr <= 16'h7FFF) |-> cart_rd);

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({boot_rd, cart_rd, cart_wr}));

  assert_sticky_off_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    !overlay_on |=> !overlay_on);

  assert_unmapped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_addr >= 16'h8000 && cpu_addr <= 16'hBFFF) |-> !(boot_rd || cart_rd || cart_wr));

  assert_absent_cart_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (cart_rd && !cart_present) |=> (cpu_rdata == 8'hFF));

  assert_read_pulse_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_acc |=> cpu_rvalid);

  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    !rd_acc |=> !cpu_rvalid);
endmodule

bind boot_overlay_router bor_chk u_chk (
  .clk(clk), .rst_ok(rst_i_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
  .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
  .boot_rd(boot_rd), .cart_rd(cart_rd), .cart_wr(cart_wr),
  .cart_present(cart_present), .overlay_on(overlay_on)
);

// File: tb/boot_overlay_router_tb.sv
`timescale 1ns/1ps
module boot_overlay_router_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic [7:0]  boot_addr;
  logic        boot_rd;
  logic [7:0]  boot_data;
  logic [15:0] cart_addr;
  logic        cart_rd;
  logic        cart_wr;
  logic [7:0]  cart_wdata;
  logic [7:0]  cart_rdata;
  logic        cart_present;

  int checks = 0;
  int bad = 0;

  boot_overlay_router u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // device models: byte is a simple function of the address
  assign boot_data  = boot_addr ^ 8'h5A;
  assign cart_rdata = cart_addr[15:8] ^ cart_addr[7:0] ^ 8'hC3;

  function automatic logic [7:0] cart_fn(logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'hC3;
  endfunction

  // reference model state
  bit         m_off;
  logic [7:0] m_wram [int];
  bit         exp_v;
  logic [7:0] exp_d;
  string      exp_req;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_off = 0;
      exp_v = 0;
    end else begin
      exp_v = cpu_rd && !cpu_wr;
      if (exp_v) begin
        if (cpu_addr <= 16'h7FFF) begin
          if (cpu_addr < 16'h0100 && !m_off) begin
            exp_d = cpu_addr[7:0] ^ 8'h5A; exp_req = "R1";
          end else if (!cart_present) begin
            exp_d = 8'hFF; exp_req = "R8";
          end else begin
            exp_d = cart_fn(cpu_addr); exp_req = (cpu_addr < 16'h0100) ? "R3" : "R2";
          end
        end else if (cpu_addr >= 16'hC000 && cpu_addr <= 16'hDFFF) begin
          exp_d = m_wram[int'(cpu_addr % 1024)]; exp_req = "R9";
        end else if (cpu_addr == 16'hFF50) begin
          exp_d = m_off ? 8'hFF : 8'hFE; exp_req = "R6";
        end else begin
          exp_d = 8'hFF; exp_req = "R7";
        end
      end
      if (cpu_wr) begin
        if (cpu_addr == 16'hFF50 && cpu_wdata == 8'h01) m_off = 1;
        if (cpu_addr >= 16'hC000 && cpu_addr <= 16'hDFFF)
          m_wram[int'(cpu_addr % 1024)] = cpu_wdata;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare registered outputs against the model, then drive the next access
  task automatic cyc(bit rd, bit wr, logic [15:0] a, logic [7:0] d);
    bit eb, ec, ew;
    @(negedge clk);
    chk(cpu_rvalid == exp_v, "R11", "rvalid", cpu_rvalid, exp_v);
    if (exp_v) chk(cpu_rdata == exp_d, exp_req, "rdata", cpu_rdata, exp_d);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    #1;
    eb = rd && !wr && a < 16'h0100 && !m_off;
    ec = rd && !wr && a <= 16'h7FFF && !eb;
    ew = wr && a <= 16'h7FFF;
    chk(boot_rd == eb, "R1", "boot_rd", boot_rd, eb);
    chk(cart_rd == ec, "R2", "cart_rd", cart_rd, ec);
    chk(cart_wr == ew, "R10", "cart_wr", cart_wr, ew);
    if (eb) chk(boot_addr == a[7:0], "R1", "boot_addr", boot_addr, a[7:0]);
    if (ec || ew) chk(cart_addr == a, "R2", "cart_addr", cart_addr, a);
    if (ew) chk(cart_wdata == d, "R10", "cart_wdata", cart_wdata, d);
  endtask

  task automatic rd(logic [15:0] a);  cyc(1, 0, a, 8'h00); endtask
  task automatic wr(logic [15:0] a, logic [7:0] d); cyc(0, 1, a, d); endtask
  task automatic idle(); cyc(0, 0, 16'h0000, 8'h00); endtask

  task automatic do_reset();
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    // R12: reset state
    chk(cpu_rvalid == 1'b0, "R12", "rvalid in reset", cpu_rvalid, 0);
    chk(cpu_rdata == 8'hFF, "R12", "rdata in reset", cpu_rdata, 8'hFF);
    rst_n = 1;
    repeat (4) idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst_n = 0; cart_present = 1;
    cpu_rd = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
    do_reset();
    // R1: boot overlay, back-to-back reads
    rd(16'h0000); rd(16'h0001); rd(16'h00FF);
    // R2: upper ROM window
    rd(16'h0100); rd(16'h4ABC); rd(16'h7FFF);
    // R6: control read while on
    rd(16'hFF50);
    // R4: other values leave overlay on
    wr(16'hFF50, 8'h00); wr(16'hFF50, 8'h02); wr(16'hFF50, 8'h81); wr(16'hFF50, 8'hFF);
    rd(16'h0010); rd(16'hFF50);
    // R10: ROM writes forwarded, including under overlay
    wr(16'h2000, 8'h05); wr(16'h0040, 8'hA7); idle();
    // R9: work RAM with aliasing
    wr(16'hC000, 8'h11); wr(16'hDFFF, 8'h22); wr(16'hC123, 8'h33);
    rd(16'hC000); rd(16'hDFFF); rd(16'hC123); rd(16'hC400); rd(16'hD123);
    wr(16'hC400, 8'h44); rd(16'hC000);
    // R7: unmapped
    rd(16'h8000); rd(16'hBFFF); rd(16'hE000); rd(16'hFF00); rd(16'hFF51); rd(16'hFFFF);
    wr(16'h9000, 8'h12); rd(16'h9000);
    // R8: absent cartridge
    cart_present = 0;
    rd(16'h1234); rd(16'h0080); rd(16'h0100);
    cart_present = 1;
    // R3: disable overlay, next access goes to cartridge
    wr(16'hFF50, 8'h01); rd(16'h0000); rd(16'h00FF); rd(16'hFF50);
    // R5: no re-enable
    wr(16'hFF50, 8'h00); wr(16'hFF50, 8'h01); wr(16'hFF50, 8'hFE);
    rd(16'h0020); rd(16'hFF50);
    cart_present = 0; rd(16'h0030); cart_present = 1;
    // both strobes: treated as a write (R11)
    cyc(1, 1, 16'h3000, 8'h9C); idle();
    // R5: reset restores overlay
    do_reset();
    rd(16'h0000); rd(16'hFF50); rd(16'h0101);
    idle(); idle();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule